// File: doc/BRIEF.md
# Descriptor-Fetching Multi-Channel DMA Engine

This block moves blocks of 32-bit words from one memory region to another without processor help. Software writes the byte address of a four-word descriptor into a channel, together with a start strobe. The engine then reads the descriptor over its own memory port. The four words are, in this order: source address, destination address, length in bytes, and burst size in beats. Each word goes directly into that channel's working registers. From then on, the copy loop acts only on those registers, so a wrong descriptor field goes straight into the transfer.

Several channels can be active at once. One sequencer owns the memory port. A round-robin arbiter hands it to one channel per turn, and a turn is either a full descriptor fetch or one burst. During a burst, up to burst-size words are read into a FIFO shared by all channels, and then written out to the destination. The arbiter skips any channel whose next burst would not fit in the free FIFO space. When a channel's last write is accepted, it clears its busy flag and raises its interrupt. The interrupt stays raised until software acknowledges it.

Top module: `dma_engine`

## Requirements
- R1: After reset, every busy flag and every interrupt line is 0, and `mem_valid` is 0.
- R2: A start on an idle channel with descriptor address P sets that channel's busy flag on the next clock edge. The engine's next four reads for that channel go to P, P+4, P+8 and P+12. Those words are taken, in that order, as source address, destination address, length in bytes, and burst size in beats.
- R3: A transfer copies floor(length/4) words, in ascending word order, from the source address to the destination address. No word past the end of the destination block is written.
- R4: A transfer is split into bursts of min(burst size, remaining words) words. Each burst performs all of its reads, then all of its writes. The number of bursts is ceil(words/burst size).
- R5: Channels that are ready are served round-robin, one turn each (a descriptor fetch or one burst). Two channels running together therefore have their bursts strictly alternate.
- R6: FIFO occupancy never exceeds DEPTH words. A burst of exactly DEPTH beats proceeds. A channel whose next burst is larger than the free FIFO space is never granted: it stays busy, raises no interrupt and writes nothing, while other channels run to completion.
- R7: A channel's interrupt rises, and its busy flag falls, on the edge that accepts the transfer's last write. The interrupt stays at 1 until its `irq_ack` bit is sampled high, and falls on that edge.
- R8: A descriptor with length 0 completes right after the descriptor fetch. It makes no data reads and no writes, and raises the interrupt.
- R9: A start strobe for a channel that is already busy is ignored: the running transfer is unchanged and no second transfer follows.
- R10: The two low bits of the length field are dropped. A length of 10 bytes moves exactly 2 words.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_write` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_we | input | 1 | Start strobe for channel `start_ch` |
| start_ch | input | CHW | Channel index for the start strobe |
| start_ptr | input | AW | Byte address of the channel's descriptor |
| irq_ack | input | NCH | Per-channel interrupt acknowledge |
| busy | output | NCH | Per-channel transfer in progress |
| irq | output | NCH | Per-channel completion interrupt |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DW | Read data, valid while a read is accepted |

## Verification
The bench runs transfers whose last burst is shorter than the rest, and a burst of exactly the FIFO depth. A design that rounds the final burst up would write past the destination block. A design that uses a strict less-than in the fit test would stall that channel forever. Two channels started together must alternate bursts; a fixed-priority arbiter would run one channel to the end first. A channel whose burst exceeds the FIFO must stay busy without blocking its neighbour. Further tests cover a zero-length descriptor, which must finish without any data traffic, a second start on a busy channel, which a careless design would act on by refetching, and a byte length that is not a multiple of four.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_READ,
      ST_WRITE
   } seq_state_t;

   localparam int DESC_WORDS = 4;
   localparam logic [1:0] FLD_SRC   = 2'd0;
   localparam logic [1:0] FLD_DST   = 2'd1;
   localparam logic [1:0] FLD_LEN   = 2'd2;
   localparam logic [1:0] FLD_BURST = 2'd3;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          take,
   output logic          any,
   output logic [IW-1:0] gnt_idx
);
   logic [IW-1:0] last;

   always_comb begin
      int c;
      any     = 1'b0;
      gnt_idx = '0;
      for (int k = 1; k <= N; k++) begin
         c = (int'(last) + k) % N;
         if (!any && req[c]) begin
            any     = 1'b1;
            gnt_idx = IW'(c);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last <= IW'(N - 1);
      else if (take && any)
         last <= gnt_idx;
   end

   // R5
   grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[gnt_idx]);
endmodule

// File: rtl/dma_fifo.sv
module dma_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [DW-1:0]   wdata,
   input  logic            pop,
   output logic [DW-1:0]   rdata,
   output logic [CNTW-1:0] count,
   output logic [CNTW-1:0] free
);
   logic [DW-1:0] store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;

   assign rdata = store[rd_ptr];
   assign free  = CNTW'(DEPTH) - count;

   always_ff @(posedge clk) begin
      if (push)
         store[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push)
            wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop)
            rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && !pop && count == CNTW'(DEPTH)));
   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && count == '0));
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_ptr,
   input  logic          ld_en,
   input  logic [1:0]    ld_idx,
   input  logic [DW-1:0] ld_data,
   input  logic          adv,
   input  logic [DW-1:0] adv_n,
   input  logic          ack,
   output logic          busy,
   output logic          irq,
   output logic          fetch_pend,
   output logic [AW-1:0] desc_ptr,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [DW-1:0] left,
   output logic [DW-1:0] nxt_n
);
   import dma_pkg::*;

   logic [DW-1:0] burst;
   logic          fin_ld, fin_adv;

   assign nxt_n   = (burst < left) ? burst : left;
   assign fin_ld  = ld_en && (ld_idx == FLD_BURST) && (left == '0);
   assign fin_adv = adv && (left == adv_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         irq        <= 1'b0;
         fetch_pend <= 1'b0;
         desc_ptr   <= '0;
         src        <= '0;
         dst        <= '0;
         left       <= '0;
         burst      <= '0;
      end else begin
         if (start && !busy) begin
            busy       <= 1'b1;
            fetch_pend <= 1'b1;
            desc_ptr   <= start_ptr;
         end
         if (ld_en) begin
            case (ld_idx)
               FLD_SRC: src  <= AW'(ld_data);
               FLD_DST: dst  <= AW'(ld_data);
               FLD_LEN: left <= ld_data >> 2;
               default: begin
                  burst      <= ld_data;
                  fetch_pend <= 1'b0;
               end
            endcase
         end
         if (adv) begin
            src  <= src + AW'({adv_n, 2'b00});
            dst  <= dst + AW'({adv_n, 2'b00});
            left <= left - adv_n;
         end
         if (fin_ld || fin_adv) begin
            busy <= 1'b0;
            irq  <= 1'b1;
         end else if (ack) begin
            irq  <= 1'b0;
         end
      end
   end

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack |=> irq);
   // R9
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(desc_ptr));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
   parameter int NCH   = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_we,
   input  logic [CHW-1:0] start_ch,
   input  logic [AW-1:0]  start_ptr,
   input  logic [NCH-1:0] irq_ack,
   output logic [NCH-1:0] busy,
   output logic [NCH-1:0] irq,
   output logic           mem_valid,
   output logic           mem_write,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic           mem_ready,
   input  logic [DW-1:0]  mem_rdata
);
   import dma_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dma_engine: DEPTH must be at least 2");
      end
      if (AW > DW) begin : g_bad_aw
         $error("dma_engine: AW must not exceed DW");
      end
   endgenerate

   seq_state_t     state;
   logic [CHW-1:0] cur;
   logic [CNTW-1:0] cnt, nbeats;
   logic           acc, take, any, last_beat;
   logic [CHW-1:0] gidx;
   logic [NCH-1:0] req, fetch_pend;
   logic [AW-1:0]  c_ptr [NCH];
   logic [AW-1:0]  c_src [NCH];
   logic [AW-1:0]  c_dst [NCH];
   logic [DW-1:0]  c_left [NCH];
   logic [DW-1:0]  c_nxt [NCH];
   logic [CNTW-1:0] fifo_count, fifo_free;
   logic [DW-1:0]  fifo_rdata;
   logic [AW-1:0]  offs;

   assign acc       = mem_valid && mem_ready;
   assign take      = (state == ST_IDLE) && any;
   assign last_beat = (cnt == nbeats - 1'b1);
   assign offs      = AW'({cnt, 2'b00});

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dma_chan #(.AW(AW), .DW(DW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start_we && (start_ch == CHW'(i))),
            .start_ptr  (start_ptr),
            .ld_en      ((state == ST_FETCH) && acc && (cur == CHW'(i))),
            .ld_idx     (cnt[1:0]),
            .ld_data    (mem_rdata),
            .adv        ((state == ST_WRITE) && acc && last_beat && (cur == CHW'(i))),
            .adv_n      (DW'(nbeats)),
            .ack        (irq_ack[i]),
            .busy       (busy[i]),
            .irq        (irq[i]),
            .fetch_pend (fetch_pend[i]),
            .desc_ptr   (c_ptr[i]),
            .src        (c_src[i]),
            .dst        (c_dst[i]),
            .left       (c_left[i]),
            .nxt_n      (c_nxt[i])
         );
         assign req[i] = fetch_pend[i] ||
                         (busy[i] && (c_left[i] != '0) && (c_nxt[i] <= DW'(fifo_free)));
      end
   endgenerate

   dma_rr_arb #(.N(NCH)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .take    (take),
      .any     (any),
      .gnt_idx (gidx)
   );

   dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  ((state == ST_READ) && acc),
      .wdata (mem_rdata),
      .pop   ((state == ST_WRITE) && acc),
      .rdata (fifo_rdata),
      .count (fifo_count),
      .free  (fifo_free)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cur    <= '0;
         cnt    <= '0;
         nbeats <= '0;
      end else begin
         case (state)
            ST_IDLE: if (take) begin
               cur <= gidx;
               cnt <= '0;
               if (fetch_pend[gidx]) begin
                  state <= ST_FETCH;
               end else begin
                  state  <= ST_READ;
                  nbeats <= CNTW'(c_nxt[gidx]);
               end
            end
            ST_FETCH: if (acc) begin
               cnt <= cnt + 1'b1;
               if (cnt == CNTW'(DESC_WORDS - 1))
                  state <= ST_IDLE;
            end
            ST_READ: if (acc) begin
               if (last_beat) begin
                  cnt   <= '0;
                  state <= ST_WRITE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: if (acc) begin
               if (last_beat)
                  state <= ST_IDLE;
               else
                  cnt <= cnt + 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      mem_valid = (state != ST_IDLE);
      mem_write = (state == ST_WRITE);
      mem_wdata = fifo_rdata;
      case (state)
         ST_FETCH: mem_addr = c_ptr[cur] + offs;
         ST_READ:  mem_addr = c_src[cur] + offs;
         ST_WRITE: mem_addr = c_dst[cur] + offs;
         default:  mem_addr = '0;
      endcase
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));
   // R4
   write_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_write |-> fifo_count != '0);
   // R6
   occupancy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNTW'(DEPTH));
endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int DEPTH = 8;

   typedef struct packed {
      logic [31:0] len;
      logic [31:0] burst;
      logic [31:0] nb;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{32'd16, 32'd4, 32'd1},
      '{32'd28, 32'd3, 32'd3},
      '{32'd32, 32'd8, 32'd1},
      '{32'd20, 32'd1, 32'd5},
      '{32'd36, 32'd4, 32'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_we = 1'b0;
   logic [1:0]  start_ch = '0;
   logic [31:0] start_ptr = '0;
   logic [NCH-1:0] irq_ack = '0;
   logic [NCH-1:0] busy, irq;
   logic        mem_valid, mem_write, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   logic [31:0] mem [0:1023];
   logic        tb_we = 1'b0;
   logic [31:0] tb_addr = '0, tb_data = '0;
   logic [31:0] acc_log [0:1023];
   logic [3:0]  own_log [0:255];
   int          n_acc = 0, n_wr = 0, n_rd = 0, n_burst = 0, hold_bad = 0;
   logic        last_wr = 1'b0, hold_pend = 1'b0, h_wr = 1'b0;
   logic [31:0] h_addr = '0;
   logic [3:0]  lfsr = 4'b1001;
   int          n_checks = 0, n_err = 0, cyc = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_engine #(.NCH(NCH), .AW(32), .DW(32), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .start_we(start_we), .start_ch(start_ch),
      .start_ptr(start_ptr), .irq_ack(irq_ack), .busy(busy), .irq(irq),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[11:2]];
   assign mem_ready = lfsr[0] | lfsr[1];

   always @(negedge clk) lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};

   always @(posedge clk) begin
      if (tb_we) mem[tb_addr[11:2]] <= tb_data;
      if (rst_n && mem_valid && hold_pend && (mem_addr !== h_addr || mem_write !== h_wr))
         hold_bad <= hold_bad + 1;
      hold_pend <= rst_n && mem_valid && !mem_ready;
      h_addr    <= mem_addr;
      h_wr      <= mem_write;
      if (rst_n && mem_valid && mem_ready) begin
         acc_log[n_acc[9:0]] <= mem_addr;
         n_acc <= n_acc + 1;
         if (mem_write) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            n_wr <= n_wr + 1;
            if (!last_wr) begin
               own_log[n_burst[7:0]] <= mem_addr[11:8];
               n_burst <= n_burst + 1;
            end
         end else begin
            n_rd <= n_rd + 1;
         end
         last_wr <= mem_write;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_checks = n_checks + 1;
         n_err = n_err + 1;
         $display("FAIL R3 watchdog expired: actual %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = a; tb_data = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic put_desc(input logic [31:0] p, input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] len, input logic [31:0] b);
      poke(p, s); poke(p + 4, d); poke(p + 8, len); poke(p + 12, b);
   endtask

   task automatic fill(input logic [31:0] s, input logic [31:0] d, input int words, input int seed);
      for (int k = 0; k < words; k++) poke(s + 4 * k, 32'hA000_0000 + (seed << 16) + k);
      for (int k = 0; k <= words; k++) poke(d + 4 * k, 32'hDEAD_BEEF);
   endtask

   task automatic start(input int ch, input logic [31:0] p);
      @(negedge clk);
      start_we = 1'b1; start_ch = 2'(ch); start_ptr = p;
      @(negedge clk);
      start_we = 1'b0;
   endtask

   task automatic wait_irq(input int ch, input string req);
      int t;
      t = 0;
      while (irq[ch] !== 1'b1 && t < 4000) begin
         @(negedge clk);
         t++;
      end
      chk(req, 32'(irq[ch]), 32'd1);
   endtask

   task automatic ack(input int ch);
      @(negedge clk);
      irq_ack[ch] = 1'b1;
      @(negedge clk);
      irq_ack[ch] = 1'b0;
      chk("R7 ack clears irq", 32'(irq[ch]), 32'd0);
   endtask

   function automatic int mism(input logic [31:0] s, input logic [31:0] d, input int words);
      int m;
      m = 0;
      for (int k = 0; k < words; k++)
         if (mem[(d >> 2) + k] !== mem[(s >> 2) + k]) m++;
      return m;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      int a0, b0, w0, r0, words;
      logic [31:0] s, d, p;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy after reset", 32'(busy), 32'd0);
      chk("R1 irq after reset", 32'(irq), 32'd0);
      chk("R1 mem_valid after reset", 32'(mem_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table walk: R2 R3 R4 R6 R7
      for (int i = 0; i < 5; i++) begin
         int ch;
         ch = i % NCH;
         s = 32'h400 + 32'(i) * 32'h40;
         d = 32'h800 + 32'(ch) * 32'h100;
         p = 32'(i) * 32'h10;
         words = int'(VECS[i].len >> 2);
         put_desc(p, s, d, VECS[i].len, VECS[i].burst);
         fill(s, d, words, i);
         a0 = n_acc; b0 = n_burst;
         start(ch, p);
         chk("R2 busy after start", 32'(busy[ch]), 32'd1);
         wait_irq(ch, "R7 irq on completion");
         chk("R7 busy low at completion", 32'(busy[ch]), 32'd0);
         if (i == 0)
            for (int k = 0; k < 4; k++)
               chk("R2 descriptor read order", acc_log[(a0 + k) & 1023], p + 32'(4 * k));
         chk("R3 copied words", 32'(mism(s, d, words)), 32'd0);
         chk("R3 word past end untouched", mem[(d >> 2) + words], 32'hDEAD_BEEF);
         chk((i == 2) ? "R6 full-depth burst count" : "R4 burst count",
             32'(n_burst - b0), VECS[i].nb);
         if (i == 1) begin
            repeat (5) @(negedge clk);
            chk("R7 irq held without ack", 32'(irq[ch]), 32'd1);
         end
         ack(ch);
      end

      // R5 round-robin alternation
      put_desc(32'h100, 32'h400, 32'h800, 32'd16, 32'd2);
      put_desc(32'h110, 32'h440, 32'h900, 32'd16, 32'd2);
      fill(32'h400, 32'h800, 4, 7);
      fill(32'h440, 32'h900, 4, 8);
      b0 = n_burst;
      start(0, 32'h100);
      start(1, 32'h110);
      wait_irq(0, "R5 ch0 done");
      wait_irq(1, "R5 ch1 done");
      for (int k = 0; k < 4; k++)
         chk("R5 burst owner alternates", 32'(own_log[(b0 + k) & 255]), (k % 2 == 0) ? 32'd8 : 32'd9);
      chk("R5 ch0 data", 32'(mism(32'h400, 32'h800, 4)), 32'd0);
      chk("R5 ch1 data", 32'(mism(32'h440, 32'h900, 4)), 32'd0);
      ack(0); ack(1);

      // R8 zero length
      put_desc(32'h120, 32'h400, 32'hA00, 32'd0, 32'd4);
      poke(32'hA00, 32'h1234_5678);
      w0 = n_wr; r0 = n_rd;
      start(1, 32'h120);
      wait_irq(1, "R8 irq for zero length");
      chk("R8 no writes", 32'(n_wr - w0), 32'd0);
      chk("R8 only descriptor reads", 32'(n_rd - r0), 32'd4);
      chk("R8 busy cleared", 32'(busy[1]), 32'd0);
      ack(1);

      // R9 start while busy ignored
      put_desc(32'h130, 32'h400, 32'h800, 32'd32, 32'd2);
      put_desc(32'h140, 32'h440, 32'h900, 32'd16, 32'd2);
      fill(32'h400, 32'h800, 8, 9);
      poke(32'h900, 32'h5A5A_5A5A);
      start(0, 32'h130);
      start(0, 32'h140);
      wait_irq(0, "R9 first transfer done");
      chk("R9 first transfer data", 32'(mism(32'h400, 32'h800, 8)), 32'd0);
      ack(0);
      repeat (100) @(negedge clk);
      chk("R9 no second transfer", 32'(busy[0]), 32'd0);
      chk("R9 second dst untouched", mem[32'h900 >> 2], 32'h5A5A_5A5A);

      // R10 length low bits dropped
      put_desc(32'h150, 32'h400, 32'hB00, 32'd10, 32'd4);
      fill(32'h400, 32'hB00, 3, 10);
      start(3, 32'h150);
      wait_irq(3, "R10 irq");
      chk("R10 two words copied", 32'(mism(32'h400, 32'hB00, 2)), 32'd0);
      chk("R10 third word untouched", mem[(32'hB00 >> 2) + 2], 32'hDEAD_BEEF);
      ack(3);

      // R6 oversize burst is skipped, other channel proceeds
      put_desc(32'h160, 32'h400, 32'hA00, 32'd64, 32'(DEPTH + 1));
      put_desc(32'h170, 32'h440, 32'hB00, 32'd16, 32'd2);
      fill(32'h440, 32'hB00, 4, 11);
      poke(32'hA00, 32'hCAFE_0000);
      start(2, 32'h160);
      start(3, 32'h170);
      wait_irq(3, "R6 other channel completes");
      chk("R6 other channel data", 32'(mism(32'h440, 32'hB00, 4)), 32'd0);
      repeat (200) @(negedge clk);
      chk("R6 oversize channel still busy", 32'(busy[2]), 32'd1);
      chk("R6 oversize channel no irq", 32'(irq[2]), 32'd0);
      chk("R6 oversize channel wrote nothing", mem[32'hA00 >> 2], 32'hCAFE_0000);
      do_reset();
      chk("R1 busy cleared by reset", 32'(busy), 32'd0);

      // R11 request held while not ready
      chk("R11 request stable until ready", 32'(hold_bad), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule